// File: doc/BRIEF.md
# PCI Interrupt Line Router

The router maps four PCI interrupt request lines (INTA# to INTD#, carried here as active-high levels) onto a bank of sixteen ISA interrupt request outputs. Each PCI line has its own byte-wide routing register. A register value below 16 names the ISA line that the PCI line drives. Any value of 16 or more disconnects that PCI line. Each ISA output is the OR of the current levels of every PCI line routed to it, so several PCI lines can share one ISA line. A line with no source is held low.

The four routing bytes make up one configuration dword at offset 0x60. They are programmed through a byte-enabled 32-bit configuration port and read back through the same port. A per-line status output reports whether each PCI line is connected and which ISA line it drives. A one-cycle pulse marks every routing update, so a downstream interrupt controller or notifier can re-sample its inputs.

Top module: `pirq_router`

## Requirements
- R1: While rst_ni is low and after its release, all four routing bytes hold 0x80. No ISA output is high, no route is enabled, and route_chg_o is low.
- R2: A routing byte with a value from 0 to 15 connects its PCI line to the ISA output of that number. The connection takes effect on the cycle after the write that loads the byte.
- R3: A routing byte of 16 or more (for example 0x10, 0x80, 0xFF) disconnects its PCI line. That line then drives no ISA output at any level.
- R4: When several PCI lines select the same ISA output, that output is the OR of their levels.
- R5: An ISA output with no connected PCI line at logic 1 is low. This includes an output whose last source has just been routed elsewhere.
- R6: On a write, byte lane k (bits 8k+7:8k) updates the routing byte of PCI line k only when cfg_be_i[k] is set. Line A is lane 0 and line D is lane 3. Lanes whose enable is clear keep their value.
- R7: cfg_rdata_o returns {D,C,B,A} when cfg_addr_i[7:2] equals 0x18, the dword at 0x60, with cfg_addr_i[1:0] ignored. It returns zero for every other dword.
- R8: A write to any dword other than 0x60 changes no routing byte.
- R9: route_en_o[k] is 1 exactly when routing byte k is below 16. In that case route_irq_o[4k+3:4k] holds its ISA line number, and it is 0 when the line is disabled. Both outputs change only on the cycle after a routing write.
- R10: route_chg_o is high for the single cycle after each write to dword 0x60 with at least one byte enable set. It is low after every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte address; bits 1:0 ignored |
| cfg_be_i | input | 4 | Byte enables for the write |
| cfg_wdata_i | input | 32 | Write data, lane k = routing byte k |
| cfg_rdata_o | output | 32 | Read data for cfg_addr_i |
| pirq_i | input | 4 | PCI interrupt levels, bit 0 = line A |
| isa_irq_o | output | 16 | ISA interrupt request levels |
| route_en_o | output | 4 | Per-line route enabled |
| route_irq_o | output | 16 | Per-line ISA target, 4 bits per line |
| route_chg_o | output | 1 | One-cycle pulse after a routing write |

## Verification
The assertions assume that every input is at a known level at each rising clock edge once reset is released. They also assume that a write is a single-cycle strobe whose address and enables are meaningful only while the strobe is high. The bench drives every input at a fixed offset after the rising edge, so the inputs are always settled when the edge arrives. Its random phase draws addresses from the routing dword, the same dword with nonzero low bits, and its neighbours. It also draws every byte-enable pattern, including all-clear, and routing bytes on both sides of the value 16.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
  localparam int unsigned NUM_PIRQ   = 4;
  localparam int unsigned NUM_ISA    = 16;
  localparam int unsigned ADDR_W     = 8;
  localparam logic [7:0]  ROUTE_BASE = 8'h60;
  localparam logic [7:0]  ROUTE_RST  = 8'h80;

  typedef logic [7:0] route_byte_t;

  function automatic logic route_connects(route_byte_t b, int unsigned n_isa);
    return 32'(b) < n_isa;
  endfunction
endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs #(
  parameter int unsigned NUM_PIRQ = 4,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h60,
  parameter logic [7:0] RST_VAL = 8'h80,
  localparam int unsigned DATA_W = NUM_PIRQ * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NUM_PIRQ-1:0] be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] route_o,
  output logic              chg_o
);
  logic hit;
  logic upd;

  // dword match, byte-offset bits ignored
  assign hit = (addr_i[ADDR_W-1:2] == BASE[ADDR_W-1:2]);
  assign upd = wr_i && hit && (|be_i);

  for (genvar k = 0; k < NUM_PIRQ; k++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        route_o[8*k +: 8] <= RST_VAL;
      end else if (wr_i && hit && be_i[k]) begin
        route_o[8*k +: 8] <= wdata_i[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chg_o <= 1'b0;
    else         chg_o <= upd;
  end

  assign rdata_o = hit ? route_o : '0;
endmodule

// File: rtl/pirq_route_decode.sv
module pirq_route_decode
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = 4,
  parameter int unsigned NUM_ISA  = 16,
  localparam int unsigned IRQ_W = $clog2(NUM_ISA)
) (
  input  logic [NUM_PIRQ*8-1:0]     route_i,
  output logic [NUM_PIRQ-1:0]       en_o,
  output logic [NUM_PIRQ*IRQ_W-1:0] irq_o
);
  for (genvar k = 0; k < NUM_PIRQ; k++) begin : g_dec
    route_byte_t b;
    assign b = route_i[8*k +: 8];
    assign en_o[k] = route_connects(b, NUM_ISA);
    assign irq_o[IRQ_W*k +: IRQ_W] = en_o[k] ? b[IRQ_W-1:0] : '0;
  end
endmodule

// File: rtl/pirq_irq_merge.sv
module pirq_irq_merge #(
  parameter int unsigned NUM_PIRQ = 4,
  parameter int unsigned NUM_ISA  = 16,
  localparam int unsigned IRQ_W = $clog2(NUM_ISA)
) (
  input  logic [NUM_PIRQ-1:0]       pirq_i,
  input  logic [NUM_PIRQ-1:0]       en_i,
  input  logic [NUM_PIRQ*IRQ_W-1:0] irq_i,
  output logic [NUM_ISA-1:0]        isa_irq_o
);
  for (genvar j = 0; j < NUM_ISA; j++) begin : g_line
    logic [NUM_PIRQ-1:0] sel;
    always_comb begin
      for (int k = 0; k < NUM_PIRQ; k++) begin
        sel[k] = en_i[k] && (irq_i[IRQ_W*k +: IRQ_W] == IRQ_W'(j));
      end
    end
    // wired-OR of every source routed here
    assign isa_irq_o[j] = |(sel & pirq_i);
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = pirq_router_pkg::NUM_PIRQ,
  parameter int unsigned NUM_ISA  = pirq_router_pkg::NUM_ISA,
  parameter int unsigned ADDR_W   = pirq_router_pkg::ADDR_W,
  localparam int unsigned IRQ_W  = $clog2(NUM_ISA),
  localparam int unsigned DATA_W = NUM_PIRQ * 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_wr_i,
  input  logic [ADDR_W-1:0]         cfg_addr_i,
  input  logic [NUM_PIRQ-1:0]       cfg_be_i,
  input  logic [DATA_W-1:0]         cfg_wdata_i,
  output logic [DATA_W-1:0]         cfg_rdata_o,
  input  logic [NUM_PIRQ-1:0]       pirq_i,
  output logic [NUM_ISA-1:0]        isa_irq_o,
  output logic [NUM_PIRQ-1:0]       route_en_o,
  output logic [NUM_PIRQ*IRQ_W-1:0] route_irq_o,
  output logic                      route_chg_o
);
  logic [DATA_W-1:0] route_q;

  pirq_cfg_regs #(
    .NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W),
    .BASE(ADDR_W'(ROUTE_BASE)), .RST_VAL(ROUTE_RST)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(cfg_wr_i), .addr_i(cfg_addr_i),
    .be_i(cfg_be_i), .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .route_o(route_q), .chg_o(route_chg_o)
  );

  pirq_route_decode #(.NUM_PIRQ(NUM_PIRQ), .NUM_ISA(NUM_ISA)) u_dec (
    .route_i(route_q), .en_o(route_en_o), .irq_o(route_irq_o)
  );

  pirq_irq_merge #(.NUM_PIRQ(NUM_PIRQ), .NUM_ISA(NUM_ISA)) u_merge (
    .pirq_i(pirq_i), .en_i(route_en_o), .irq_i(route_irq_o),
    .isa_irq_o(isa_irq_o)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int unsigned NUM_PIRQ = 4,
  parameter int unsigned NUM_ISA  = 16,
  parameter int unsigned ADDR_W   = 8,
  localparam int unsigned IRQ_W  = $clog2(NUM_ISA),
  localparam int unsigned DATA_W = NUM_PIRQ * 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      cfg_wr_i,
  input logic [ADDR_W-1:0]         cfg_addr_i,
  input logic [NUM_PIRQ-1:0]       cfg_be_i,
  input logic [DATA_W-1:0]         cfg_rdata_o,
  input logic [NUM_PIRQ-1:0]       pirq_i,
  input logic [NUM_ISA-1:0]        isa_irq_o,
  input logic [NUM_PIRQ-1:0]       route_en_o,
  input logic [NUM_PIRQ*IRQ_W-1:0] route_irq_o,
  input logic                      route_chg_o
);
  logic in_dw;
  logic touch;
  assign in_dw = (cfg_addr_i[ADDR_W-1:2] == 6'h18);
  assign touch = cfg_wr_i && in_dw && (|cfg_be_i);

  // R5
  no_phantom_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|isa_irq_o) |-> (|(pirq_i & route_en_o)));

  // R7
  off_dw_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_dw |-> (cfg_rdata_o == '0));

  // R8
  off_dw_write_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && !in_dw) |=> ($stable(route_en_o) && $stable(route_irq_o)));

  // R9
  status_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route_chg_o |-> ($stable(route_en_o) && $stable(route_irq_o)));

  // R10
  chg_after_touch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch |=> route_chg_o);

  // R10
  chg_only_touch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !touch |=> !route_chg_o);

  for (genvar k = 0; k < NUM_PIRQ; k++) begin : g_line
    // R2
    routed_drives_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (route_en_o[k] && pirq_i[k]) |-> isa_irq_o[route_irq_o[IRQ_W*k +: IRQ_W]]);
    // R9
    disabled_zero_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !route_en_o[k] |-> (route_irq_o[IRQ_W*k +: IRQ_W] == '0));
  end
endmodule

bind pirq_router pirq_router_chk #(
  .NUM_PIRQ(NUM_PIRQ), .NUM_ISA(NUM_ISA), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i),
  .cfg_be_i(cfg_be_i), .cfg_rdata_o(cfg_rdata_o), .pirq_i(pirq_i),
  .isa_irq_o(isa_irq_o), .route_en_o(route_en_o), .route_irq_o(route_irq_o),
  .route_chg_o(route_chg_o)
);

// File: tb/pirq_router_test.sv
module pirq_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = 8'h60;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  pirq = 4'h0;
  logic [15:0] isa_irq;
  logic [3:0]  route_en;
  logic [15:0] route_irq;
  logic        route_chg;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  int  rb[4] = '{128, 128, 128, 128};
  bit  m_chg = 1'b0;

  always #10 clk = ~clk;

  pirq_router uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
    .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .pirq_i(pirq), .isa_irq_o(isa_irq), .route_en_o(route_en),
    .route_irq_o(route_irq), .route_chg_o(route_chg)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (rb[k]) rb[k] = 128;
      m_chg = 1'b0;
    end else begin
      bit match;
      match = (cfg_addr >= 8'h60) && (cfg_addr <= 8'h63);
      m_chg = cfg_wr && match && (cfg_be != 0);
      if (cfg_wr && match)
        for (int k = 0; k < 4; k++)
          if (cfg_be[k]) rb[k] = int'(cfg_wdata[8*k +: 8]);
    end
  end

  function automatic logic [15:0] m_isa();
    logic [15:0] v = '0;
    for (int k = 0; k < 4; k++)
      if (rb[k] < 16 && pirq[k]) v[rb[k]] = 1'b1;
    return v;
  endfunction

  function automatic logic [3:0] m_en();
    logic [3:0] v;
    for (int k = 0; k < 4; k++) v[k] = (rb[k] < 16);
    return v;
  endfunction

  function automatic logic [15:0] m_irq();
    logic [15:0] v = '0;
    for (int k = 0; k < 4; k++) if (rb[k] < 16) v[4*k +: 4] = 4'(rb[k]);
    return v;
  endfunction

  function automatic logic [31:0] m_rd();
    if (cfg_addr >= 8'h60 && cfg_addr <= 8'h63)
      return {8'(rb[3]), 8'(rb[2]), 8'(rb[1]), 8'(rb[0])};
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // model compared on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 isa_irq_o", 32'(isa_irq), 32'(m_isa()));
      chk("R9 route_en_o", 32'(route_en), 32'(m_en()));
      chk("R9 route_irq_o", 32'(route_irq), 32'(m_irq()));
      chk("R7 cfg_rdata_o", cfg_rdata, m_rd());
      chk("R10 route_chg_o", 32'(route_chg), 32'(m_chg));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(posedge clk); #5;
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(posedge clk); #5;
    cfg_wr = 1'b0; cfg_be = 4'h0; cfg_addr = 8'h60;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R1: state during reset
    chk("R1 isa in reset", 32'(isa_irq), 32'h0);
    chk("R1 chg in reset", 32'(route_chg), 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #5;
    pirq = 4'hF; #1;
    chk("R1 isa after reset", 32'(isa_irq), 32'h0);
    chk("R1 route_en", 32'(route_en), 32'h0);
    chk("R1 rdata", cfg_rdata, 32'h80808080);

    // R2: A->3, B->5, C->11, D stays off
    wr(8'h60, 4'hF, 32'h800B0503);
    chk("R10 pulse after write", 32'(route_chg), 32'h1);
    #1;
    chk("R2 isa", 32'(isa_irq), 32'h0828);
    chk("R9 en", 32'(route_en), 32'h7);
    chk("R9 irq", 32'(route_irq), 32'h0B53);
    @(posedge clk); #5;
    chk("R10 pulse one cycle", 32'(route_chg), 32'h0);

    // R3: D at 0x10 and 0xFF stays off; 15 connects
    pirq = 4'b1000;
    wr(8'h63, 4'b1000, 32'h10000000); #1;
    chk("R3 0x10 off", 32'(isa_irq), 32'h0);
    wr(8'h60, 4'b1000, 32'hFF000000); #1;
    chk("R3 0xFF off", 32'(isa_irq), 32'h0);
    chk("R3 en", 32'(route_en), 32'h7);
    wr(8'h60, 4'b1000, 32'h0F000000); #1;
    chk("R2 boundary 15", 32'(isa_irq), 32'h8000);

    // R4: A and B share line 7
    wr(8'h60, 4'b0011, 32'hEEEE0707);
    pirq = 4'b0001; #1; chk("R4 A only", 32'(isa_irq), 32'h0080);
    pirq = 4'b0010; #1; chk("R4 B only", 32'(isa_irq), 32'h0080);
    pirq = 4'b0011; #1; chk("R4 both", 32'(isa_irq), 32'h0080);
    pirq = 4'b0000; #1; chk("R5 none", 32'(isa_irq), 32'h0);

    // R5: move A off line 7 while high
    pirq = 4'b0001;
    wr(8'h60, 4'b0001, 32'h00000009); #1;
    chk("R5 reroute", 32'(isa_irq), 32'h0200);

    // R6: only lane 1 enabled
    wr(8'h60, 4'b0010, 32'hAAAA0CAA); #1;
    chk("R6 byte enable", cfg_rdata, 32'h0F0B0C09);

    // R8 / R7: other dword
    wr(8'h64, 4'hF, 32'h01010101);
    chk("R10 no pulse off dword", 32'(route_chg), 32'h0);
    #1;
    chk("R8 unchanged", cfg_rdata, 32'h0F0B0C09);
    cfg_addr = 8'h64; #1;
    chk("R7 other dword zero", cfg_rdata, 32'h0);
    cfg_addr = 8'h62; #1;
    chk("R7 low bits ignored", cfg_rdata, 32'h0F0B0C09);
    cfg_addr = 8'h60;

    // R10: no enables -> no pulse, no change
    wr(8'h60, 4'h0, 32'h01010101);
    chk("R10 no pulse be=0", 32'(route_chg), 32'h0);
    #1;
    chk("R9 en final", 32'(route_en), 32'hF);
    chk("R9 irq final", 32'(route_irq), 32'hFBC9);

    // random phase, checked by the model each cycle
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #5;
      pirq = 4'($urandom);
      cfg_wr = ($urandom % 3) == 0;
      case ($urandom % 4)
        0: cfg_addr = 8'h60;
        1: cfg_addr = 8'h60 | 8'($urandom % 4);
        2: cfg_addr = 8'h64;
        default: cfg_addr = 8'h5C;
      endcase
      cfg_be = 4'($urandom);
      for (int k = 0; k < 4; k++)
        cfg_wdata[8*k +: 8] = ($urandom % 3 != 0) ? 8'($urandom % 16) : 8'($urandom);
    end
    @(posedge clk); #5;
    cfg_wr = 1'b0;
    repeat (2) @(posedge clk);
    #5;
    finish_run();
  end
endmodule